// File: doc/BRIEF.md
# Serial Result Readout Port

This block is the slave side of a three-wire serial link through which a host collects conversion results. In command mode it collects bytes from the data input. A conversion byte moves it into data mode. A calibration byte is passed on to the conversion side, and the port stays in command mode. Any other byte is ignored.

In data mode the port waits for the conversion side to report a finished batch. It then pulls the output line low as a ready flag. The host gives one byte of clocks with the input held low to clear the flag. The port then shifts out the batch's 24-bit results from its result FIFO, most significant bit first, in the order they were written.

A one-shot batch returns the port to command mode once the last result is out. In continuous mode the port goes back to waiting for the next batch. If the host sends an all-ones byte during the flag-clear slot, the port leaves continuous mode, but only after the rest of that batch has been read out.

The serial clock is oversampled on the system clock through a synchronizer. The input line is taken at the rising serial clock edge, and the output changes after the falling edge.

Top module: `serial_readout_port`

## Requirements
- R1: After reset, sdo is high, and conv_active, conv_cont and underrun are low.
- R2: In command mode, a received byte with bit 7 set and bits 2..0 zero produces a one-cycle conv_req pulse. conv_cont takes the value of bit 6 (1 means continuous, 0 means one-shot), and conv_active rises as the port enters data mode.
- R3: In command mode, a byte with bit 7 set, bits 2..0 nonzero and not all ones produces a one-cycle cal_req pulse. The port stays in command mode, so a later batch_ready does not lower sdo.
- R4: In command mode, a byte with bit 7 clear, or the byte 0xFF, causes no pulse and no mode change.
- R5: When batch_ready arrives while the port waits in data mode, sdo goes low within two system clocks. It stays low for the 8 serial clocks of the flag-clear slot.
- R6: After the flag-clear slot, each result takes 24 serial clocks, sent most significant bit first and in FIFO write order. Input is sampled on the rising serial edge, and output changes after the falling serial edge.
- R7: In one-shot mode, after batch_len results have been sent, the port returns to command mode. From the next falling serial edge sdo is high, and conv_active is low.
- R8: In continuous mode without an exit request, the port waits again after batch_len results with sdo high and conv_active high. The next batch_ready lowers the flag again.
- R9: In continuous mode, a flag-clear byte of 0xFF requests an exit. All batch_len results are still sent, conv_active stays high until the last of them is done, and the port then returns to command mode.
- R10: A slot that starts with the FIFO empty sends 24 zero bits and sets underrun, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host; low level is the ready flag |
| res_wr_en | input | 1 | Write strobe for the result FIFO |
| res_wr_data | input | RES_W | Result written into the FIFO |
| batch_ready | input | 1 | Pulse: a batch of results is complete |
| batch_len | input | LEN_W | Number of results in the batch (0 read as 1) |
| conv_req | output | 1 | Pulse: start conversions |
| conv_cont | output | 1 | Conversion mode: 1 continuous, 0 one-shot |
| cal_req | output | 1 | Pulse: calibration requested |
| conv_active | output | 1 | Port is in data mode |
| underrun | output | 1 | Sticky: a result slot found the FIFO empty |

## Verification
A wrong bit or slot counter shows up on sdo as a shifted or truncated result within one 24-clock slot. The host also sees sdo go high or stay low at the wrong serial clock at the end of a batch. A wrong mode state shows up on conv_active, or as a ready flag that appears or is missing after batch_ready, within two system clocks of the event. A lost exit request shows up as conv_active still high after the final result of the exit batch.

// File: rtl/rdo_pkg.sv
// Shared types for the serial result readout port.
package rdo_pkg;
    // Port modes: command reception, waiting for a batch, flag clear, result shifting.
    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CLEAR = 2'd2,
        ST_SHIFT = 2'd3
    } rdo_state_e;

    localparam logic [7:0] EXIT_BYTE = 8'hFF;
endpackage

// File: rtl/rdo_sck_edge.sv
// Synchronizes the serial clock and data input into the system clock domain
// and produces single-cycle rise and fall strobes.
// Assumes each serial clock phase lasts several system clocks.
module rdo_sck_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic sdi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    logic [SYNC_STAGES:0] sck_sr;
    logic [SYNC_STAGES:0] sdi_sr;

    // Shift the raw lines through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sr <= '0;
            sdi_sr <= '0;
        end else begin
            sck_sr <= {sck_sr[SYNC_STAGES-1:0], sck};
            sdi_sr <= {sdi_sr[SYNC_STAGES-1:0], sdi};
        end
    end

    // Compare the two oldest samples to find edges.
    always_comb begin
        sck_rise = sck_sr[SYNC_STAGES-1] & ~sck_sr[SYNC_STAGES];
        sck_fall = ~sck_sr[SYNC_STAGES-1] & sck_sr[SYNC_STAGES];
        sdi_s    = sdi_sr[SYNC_STAGES-1];
    end
endmodule

// File: rtl/rdo_fifo.sv
// Result FIFO with show-ahead output. Writes when full and reads when empty
// are dropped. Assumes DEPTH is a power of two.
module rdo_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd, full;

    // Accept only operations the fill level allows.
    always_comb begin
        full    = (cnt == AW'(0) + (AW+1)'(DEPTH));
        empty   = (cnt == '0);
        do_wr   = wr_en & ~full;
        do_rd   = rd_en & ~empty;
        rd_data = mem[rd_ptr];
    end

    // Store incoming results.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));

    assert_empty_pop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (cnt == '0));
endmodule

// File: rtl/rdo_ctrl.sv
// Mode controller and shifter. It decodes command bytes, raises the ready
// flag, counts the flag-clear byte and shifts results out MSB first.
// Assumes one-cycle rise/fall strobes from the edge detector.
module rdo_ctrl
    import rdo_pkg::*;
#(
    parameter int W     = 24,
    parameter int LEN_W = 5,
    localparam int BW   = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             sdi_s,
    input  logic             batch_ready,
    input  logic [LEN_W-1:0] batch_len,
    input  logic             fifo_empty,
    input  logic [W-1:0]     fifo_data,
    output logic             fifo_pop,
    output logic             sdo,
    output logic             conv_req,
    output logic             conv_cont,
    output logic             cal_req,
    output logic             conv_active,
    output logic             underrun
);
    rdo_state_e       st_q;
    logic [BW-1:0]    bit_q;
    logic [7:0]       byte_q;
    logic [7:0]       nb;
    logic [LEN_W-1:0] len_q, rd_q;
    logic [W-1:0]     sh_q;
    logic             sdo_q, exit_q, cont_q, act_q, creq_q, cal_q, unf_q;
    logic             slot_start, slot_end;

    // Byte under assembly, slot boundaries and the FIFO pop request.
    always_comb begin
        nb         = {byte_q[6:0], sdi_s};
        slot_start = (st_q == ST_SHIFT) && sck_fall && (bit_q == '0);
        slot_end   = (st_q == ST_SHIFT) && sck_rise && (bit_q == BW'(W-1));
        fifo_pop   = slot_start & ~fifo_empty;
    end

    // Main mode sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_CMD;
            bit_q  <= '0;
            byte_q <= '0;
            len_q  <= '0;
            rd_q   <= '0;
            sh_q   <= '0;
            sdo_q  <= 1'b1;
            exit_q <= 1'b0;
            cont_q <= 1'b0;
            act_q  <= 1'b0;
            creq_q <= 1'b0;
            cal_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            creq_q <= 1'b0;
            cal_q  <= 1'b0;
            case (st_q)
                ST_CMD: begin
                    if (sck_fall) sdo_q <= 1'b1;
                    if (sck_rise) begin
                        byte_q <= nb;
                        if (bit_q == BW'(7)) begin
                            bit_q <= '0;
                            if (nb[7] && nb[2:0] == 3'b000) begin
                                creq_q <= 1'b1;
                                cont_q <= nb[6];
                                act_q  <= 1'b1;
                                st_q   <= ST_WAIT;
                            end else if (nb[7] && nb != EXIT_BYTE) begin
                                cal_q <= 1'b1;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (sck_fall) sdo_q <= 1'b1;
                    if (batch_ready) begin
                        st_q   <= ST_CLEAR;
                        sdo_q  <= 1'b0;
                        bit_q  <= '0;
                        exit_q <= 1'b0;
                        len_q  <= (batch_len == '0) ? LEN_W'(1) : batch_len;
                    end
                end
                ST_CLEAR: begin
                    if (sck_rise) begin
                        byte_q <= nb;
                        if (bit_q == BW'(7)) begin
                            bit_q  <= '0;
                            rd_q   <= '0;
                            exit_q <= cont_q && (nb == EXIT_BYTE);
                            st_q   <= ST_SHIFT;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (slot_start) begin
                        if (fifo_empty) begin
                            sdo_q <= 1'b0;
                            sh_q  <= '0;
                            unf_q <= 1'b1;
                        end else begin
                            sdo_q <= fifo_data[W-1];
                            sh_q  <= {fifo_data[W-2:0], 1'b0};
                        end
                    end else if (sck_fall) begin
                        sdo_q <= sh_q[W-1];
                        sh_q  <= {sh_q[W-2:0], 1'b0};
                    end
                    if (slot_end) begin
                        bit_q <= '0;
                        rd_q  <= rd_q + 1'b1;
                        if (rd_q == len_q - 1'b1) begin
                            if (!cont_q || exit_q) begin
                                st_q   <= ST_CMD;
                                act_q  <= 1'b0;
                                cont_q <= 1'b0;
                            end else begin
                                st_q <= ST_WAIT;
                            end
                        end
                    end else if (sck_rise) begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                default: st_q <= ST_CMD;
            endcase
        end
    end

    assign sdo         = sdo_q;
    assign conv_req    = creq_q;
    assign conv_cont   = cont_q;
    assign cal_req     = cal_q;
    assign conv_active = act_q;
    assign underrun    = unf_q;

    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    assert_cal_in_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |-> (st_q == ST_CMD));

    assert_flag_low_in_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CLEAR) |-> !sdo);

    assert_active_in_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_CMD) |-> conv_active);

    assert_mode_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_CMD && $past(st_q) != ST_CMD) |-> $stable(conv_cont));

    assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/serial_readout_port.sv
// Top level of the serial result readout port: edge detector, result FIFO
// and mode controller. Assumes the serial clock is much slower than clk.
module serial_readout_port #(
    parameter int RES_W       = 24,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LEN_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             sdi,
    output logic             sdo,
    input  logic             res_wr_en,
    input  logic [RES_W-1:0] res_wr_data,
    input  logic             batch_ready,
    input  logic [LEN_W-1:0] batch_len,
    output logic             conv_req,
    output logic             conv_cont,
    output logic             cal_req,
    output logic             conv_active,
    output logic             underrun
);
    logic             sck_rise, sck_fall, sdi_s;
    logic             fifo_pop, fifo_empty;
    logic [RES_W-1:0] fifo_data;

    rdo_sck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sdi      (sdi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_s    (sdi_s)
    );

    rdo_fifo #(.W(RES_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr_en),
        .wr_data (res_wr_data),
        .rd_en   (fifo_pop),
        .rd_data (fifo_data),
        .empty   (fifo_empty)
    );

    rdo_ctrl #(.W(RES_W), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .sdi_s       (sdi_s),
        .batch_ready (batch_ready),
        .batch_len   (batch_len),
        .fifo_empty  (fifo_empty),
        .fifo_data   (fifo_data),
        .fifo_pop    (fifo_pop),
        .sdo         (sdo),
        .conv_req    (conv_req),
        .conv_cont   (conv_cont),
        .cal_req     (cal_req),
        .conv_active (conv_active),
        .underrun    (underrun)
    );
endmodule

// File: tb/tb_serial_readout_port.sv
module tb_serial_readout_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        res_wr_en = 1'b0;
    logic [23:0] res_wr_data = '0;
    logic        batch_ready = 1'b0;
    logic [4:0]  batch_len = '0;
    logic        conv_req, conv_cont, cal_req, conv_active, underrun;

    int n_chk = 0;
    int n_bad = 0;
    int n_creq = 0;
    int n_cal = 0;
    logic [23:0] model_q[$];

    serial_readout_port dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sdo(sdo),
        .res_wr_en(res_wr_en), .res_wr_data(res_wr_data),
        .batch_ready(batch_ready), .batch_len(batch_len),
        .conv_req(conv_req), .conv_cont(conv_cont), .cal_req(cal_req),
        .conv_active(conv_active), .underrun(underrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n && conv_req) n_creq++;
        if (rst_n && cal_req) n_cal++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial clock: drive sdi while low, sample sdo just before the rise.
    task automatic sck_cycle(input logic din, output logic dout);
        @(negedge clk) sdi = din;
        repeat (7) @(negedge clk);
        dout = sdo;
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic d;
        for (int i = 7; i >= 0; i--) sck_cycle(b[i], d);
        repeat (4) @(negedge clk);
    endtask

    task automatic push(input logic [23:0] v);
        @(negedge clk);
        res_wr_en = 1'b1;
        res_wr_data = v;
        @(negedge clk);
        res_wr_en = 1'b0;
        model_q.push_back(v);
    endtask

    task automatic ready(input int len);
        @(negedge clk);
        batch_ready = 1'b1;
        batch_len = 5'(len);
        @(negedge clk);
        batch_ready = 1'b0;
        @(negedge clk);
        check(sdo == 1'b0, "R5 flag low after batch_ready", 32'(sdo), 0);
    endtask

    function automatic logic [23:0] expect_next();
        if (model_q.size() == 0) return 24'h0;
        return model_q.pop_front();
    endfunction

    // Clear byte, then len results compared against the model.
    task automatic read_batch(input int len, input logic [7:0] clr, input bit exiting);
        logic d;
        logic [23:0] got, exp;
        bit flag_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck_cycle(clr[i], d);
            if (d !== 1'b0) flag_ok = 1'b0;
        end
        check(flag_ok, "R5 flag held through clear byte", 32'(flag_ok), 1);
        for (int r = 0; r < len; r++) begin
            if (exiting && r == len - 1)
                check(conv_active == 1'b1, "R9 active until last result", 32'(conv_active), 1);
            exp = expect_next();
            for (int b = 0; b < 24; b++) begin
                sck_cycle(1'b0, d);
                got = {got[22:0], d};
            end
            check(got == exp, "R6 result data MSB first in order", 32'(got), 32'(exp));
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(sdo == 1'b1, "R1 sdo idle high", 32'(sdo), 1);
        check(conv_active == 1'b0, "R1 conv_active low", 32'(conv_active), 0);
        check(conv_cont == 1'b0, "R1 conv_cont low", 32'(conv_cont), 0);
        check(underrun == 1'b0, "R1 underrun low", 32'(underrun), 0);

        // R4 ignored bytes: bit 7 clear and all ones
        send_byte(8'h12);
        send_byte(8'hFF);
        check(n_creq == 0 && n_cal == 0, "R4 no pulse for ignored bytes", 32'(n_creq + n_cal), 0);
        check(conv_active == 1'b0, "R4 stays in command mode", 32'(conv_active), 0);

        // R3 calibration byte stays in command mode
        send_byte(8'h85);
        check(n_cal == 1, "R3 cal_req pulse", 32'(n_cal), 1);
        check(conv_active == 1'b0, "R3 no data mode", 32'(conv_active), 0);
        @(negedge clk) batch_ready = 1'b1;
        @(negedge clk) batch_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(sdo == 1'b1, "R3 no flag in command mode", 32'(sdo), 1);

        // R2 one-shot conversion, R6/R7 six random results
        send_byte(8'h80);
        check(n_creq == 1, "R2 conv_req pulse", 32'(n_creq), 1);
        check(conv_active == 1'b1 && conv_cont == 1'b0, "R2 one-shot data mode",
              32'({conv_active, conv_cont}), 32'h2);
        for (int i = 0; i < 6; i++) push(24'($urandom()));
        ready(6);
        read_batch(6, 8'h00, 1'b0);
        check(sdo == 1'b1, "R7 sdo high after batch", 32'(sdo), 1);
        check(conv_active == 1'b0, "R7 back to command mode", 32'(conv_active), 0);

        // R8 continuous, two ordinary batches with directed corner values
        send_byte(8'hC0);
        check(conv_cont == 1'b1 && conv_active == 1'b1, "R2 continuous mode",
              32'({conv_active, conv_cont}), 32'h3);
        push(24'hFFFFFF); push(24'h000001); push(24'h800000);
        ready(3);
        read_batch(3, 8'h00, 1'b0);
        check(conv_active == 1'b1 && sdo == 1'b1, "R8 waiting again",
              32'({conv_active, sdo}), 32'h3);
        for (int i = 0; i < 3; i++) push(24'($urandom()));
        ready(3);
        read_batch(3, 8'h00, 1'b0);
        check(conv_active == 1'b1, "R8 still active", 32'(conv_active), 1);

        // R9 exit byte during clear slot, deferred to batch end
        for (int i = 0; i < 4; i++) push(24'($urandom()));
        ready(4);
        read_batch(4, 8'hFF, 1'b1);
        check(conv_active == 1'b0 && sdo == 1'b1, "R9 exit after batch",
              32'({conv_active, sdo}), 32'h1);
        check(conv_cont == 1'b0, "R9 mode cleared", 32'(conv_cont), 0);

        // R10 underrun: batch of two with one stored result
        c0 = n_creq;
        send_byte(8'h80);
        check(n_creq == c0 + 1, "R2 second conv_req", 32'(n_creq), 32'(c0 + 1));
        check(underrun == 1'b0, "R10 no underrun yet", 32'(underrun), 0);
        push(24'h5A5A5A);
        ready(2);
        read_batch(2, 8'h00, 1'b0);
        check(underrun == 1'b1, "R10 underrun set", 32'(underrun), 1);
        send_byte(8'h12);
        check(underrun == 1'b1, "R10 underrun sticky", 32'(underrun), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule